// File: doc/BRIEF.md
# Dual-Bank Flash Write-Status Responder

This block answers reads on behalf of a flash device split into two banks while one of them runs a program or erase. A command decoder elsewhere sends one start pulse that carries the operation kind, the last loaded address and the last loaded data word. The block keeps one controller per bank. Each controller has an internal busy timer whose length depends on the operation kind. While a bank is busy, every read that targets it returns a status word and not array contents. That word carries a complement-data polling bit and a toggle bit. The other bank keeps returning its stored words. An open-drain-style ready/busy request is raised for as long as any operation runs.

The array is a small register file. It resets to the erased value, all ones. When an operation completes, the array takes the programmed word, or it takes all ones over the erased sector, block or bank. Identification codes can be read only when both banks are idle.

Each bank controller has two states. BK_IDLE moves to BK_BUSY when the controller is given an accepted start ("launch"). BK_BUSY counts its timer down and returns to BK_IDLE in the cycle in which the count reaches zero ("finish"). The array update is applied on that same finishing edge.

Top module: `dbs_responder`

## Requirements
- R1: The bank is decoded from the two top address bits. When both bits are 1 the address belongs to the small bank, the upper quarter of the space. Any other value belongs to the large bank.
- R2: `op_kind` encodes the operation as 0 = word program, 1 = sector erase, 2 = block erase, 3 = bank erase. An accepted start keeps the addressed bank busy for exactly T_PROG, T_SECT, T_BLK or T_BANK clock cycles respectively, counted from the edge that samples `op_start`.
- R3: `ryby_pull` is 1 in every cycle in which either bank is busy and 0 otherwise.
- R4: A start pulse that arrives while any bank is busy is dropped. It does not lengthen the running operation, it starts nothing afterwards and it alters no stored word.
- R5: Each read strobe gives `rd_valid` one cycle later. A read of an idle bank returns the stored word at `rd_addr`, even while the other bank is busy.
- R6: A read of a busy bank returns a status word in which every bit is 0 except bits 7 and 6. Bit 7 is the complement of bit 7 of the loaded word for a program, and 0 for any erase.
- R7: Bit 6 of the status word is 1 on the first read of the busy bank after a start. It inverts on every further read of that bank. Cycles without a read of that bank do not change it.
- R8: When a program completes, the word at the loaded address takes the loaded data. When an erase completes, all ones is written to the words that share address bits above bit SECT_W (sector), above bit BLK_W (block), or the bank (bank erase).
- R9: A read with `rd_id` set while no bank is busy returns MAKER_ID if address bit 0 is 0. If address bit 0 is 1 it returns ID_LARGE or ID_SMALL for the addressed bank. While any bank is busy, `rd_id` is ignored and the read behaves as in R5 and R6.
- R10: After reset both banks are idle, `ryby_pull` and `rd_valid` are 0, and every stored word is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle start of a program or erase |
| op_kind | input | 2 | Operation kind, coded as in R2 |
| op_addr | input | ADDR_W | Last loaded address; selects bank, sector, block or word |
| op_data | input | DW | Last loaded data word |
| rd_stb | input | 1 | One-cycle read request |
| rd_id | input | 1 | Read asks for an identification code |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_stb` |
| rd_data | output | DW | Read result: stored word, status word or identification code |
| ryby_pull | output | 1 | Request to pull the shared ready/busy line low |

## Verification
The bench builds the block with an 8-bit address, 8-word sectors, 32-word blocks and busy lengths of 3, 5, 7 and 9 cycles. With these values the whole 256-word array can be programmed word by word and then read back in full after every completion. Each erase kind and both banks are covered, and the 0xBF/0xC0 boundary between the banks is exercised. The 7-cycle block erase leaves enough cycles for a run of status reads interleaved with reads of the other bank. A dropped start and the exact busy length of every operation kind are observed within the same run.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_BANK = 2'd3
    } op_kind_e;

    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_BUSY = 1'b1
    } bank_st_e;

endpackage

// File: rtl/dbs_bank_ctl.sv
module dbs_bank_ctl
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 16,
    parameter int CNT_W  = 4,
    parameter int T_PROG = 3,
    parameter int T_SECT = 5,
    parameter int T_BLK  = 7,
    parameter int T_BANK = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     data_i,
    input  logic              rd_hit,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DW-1:0]     data_o,
    output logic              poll_o,
    output logic              tog_o
);

    bank_st_e          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, load_val;
    op_kind_e          kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     data_q;
    logic              tog_q;

    always_comb begin
        unique case (op_kind_e'(kind_i))
            OP_PROG: load_val = CNT_W'(T_PROG - 1);
            OP_SECT: load_val = CNT_W'(T_SECT - 1);
            OP_BLK:  load_val = CNT_W'(T_BLK - 1);
            OP_BANK: load_val = CNT_W'(T_BANK - 1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_IDLE: if (go)            st_d = BK_BUSY;
            BK_BUSY: if (cnt_q == '0)   st_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BK_IDLE;
            cnt_q  <= '0;
            kind_q <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            tog_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == BK_IDLE && go) begin
                cnt_q  <= load_val;
                kind_q <= op_kind_e'(kind_i);
                addr_q <= addr_i;
                data_q <= data_i;
                tog_q  <= 1'b0;
            end else if (st_q == BK_BUSY) begin
                if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                if (rd_hit)      tog_q <= ~tog_q;
            end
        end
    end

    always_comb begin
        busy_o = (st_q == BK_BUSY);
        done_o = (st_q == BK_BUSY) && (cnt_q == '0);
        kind_o = kind_q;
        addr_o = addr_q;
        data_o = data_q;
        poll_o = (kind_q == OP_PROG) ? ~data_q[7] : 1'b0;
        tog_o  = tog_q;
    end

    // R2: the timer steps down by one every busy cycle until it expires
    p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_BUSY && cnt_q != '0) |=>
            (st_q == BK_BUSY && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4: the latched operation cannot be replaced while busy
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_BUSY) |=> ($stable(kind_q) && $stable(addr_q) && $stable(data_q)));

    // R7: the toggle bit only moves on a read of this bank
    p_tog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_BUSY && !rd_hit) |=> $stable(tog_q));

endmodule

// File: rtl/dbs_word_store.sv
module dbs_word_store
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 16,
    parameter int SECT_W = 3,
    parameter int BLK_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_word
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int TOP   = ADDR_W - 1;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] wr_val;

    function automatic logic covers(input logic [ADDR_W-1:0] a,
                                    input logic [1:0]        k,
                                    input logic [ADDR_W-1:0] t);
        unique case (op_kind_e'(k))
            OP_PROG: return a == t;
            OP_SECT: return a[TOP:SECT_W] == t[TOP:SECT_W];
            OP_BLK:  return a[TOP:BLK_W] == t[TOP:BLK_W];
            OP_BANK: return (a[TOP] & a[TOP-1]) == (t[TOP] & t[TOP-1]);
        endcase
    endfunction

    assign wr_val  = (op_kind_e'(wr_kind) == OP_PROG) ? wr_data : '1;
    assign rd_word = mem[rd_addr];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (wr_en && covers(ADDR_W'(i), wr_kind, wr_addr))
                mem[i] <= wr_val;
        end
    end

endmodule

// File: rtl/dbs_responder.sv
module dbs_responder
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 16,
    parameter int SECT_W = 3,
    parameter int BLK_W  = 5,
    parameter int T_PROG = 3,
    parameter int T_SECT = 5,
    parameter int T_BLK  = 7,
    parameter int T_BANK = 9,
    parameter logic [DW-1:0] MAKER_ID = 'h00A7,
    parameter logic [DW-1:0] ID_LARGE = 'h3C11,
    parameter logic [DW-1:0] ID_SMALL = 'h3C12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DW-1:0]     op_data,
    input  logic              rd_stb,
    input  logic              rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              ryby_pull
);

    localparam int NB    = 2;
    localparam int TOP   = ADDR_W - 1;
    localparam int TM_A  = (T_PROG > T_SECT) ? T_PROG : T_SECT;
    localparam int TM_B  = (T_BLK > T_BANK) ? T_BLK : T_BANK;
    localparam int TMAX  = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int CNT_W = $clog2(TMAX + 1);

    logic [NB-1:0]     busy, done, poll, tog, go, rd_hit;
    logic [1:0]        c_kind [NB];
    logic [ADDR_W-1:0] c_addr [NB];
    logic [DW-1:0]     c_data [NB];
    logic              any_busy, op_bank, rd_bank, wr_sel;
    logic [DW-1:0]     arr_word, id_word, st_word, rd_next;

    assign op_bank  = op_addr[TOP] & op_addr[TOP-1];
    assign rd_bank  = rd_addr[TOP] & rd_addr[TOP-1];
    assign any_busy = |busy;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign go[b]     = op_start && !any_busy && (op_bank == (b == 1));
        assign rd_hit[b] = rd_stb && (rd_bank == (b == 1));

        dbs_bank_ctl #(
            .ADDR_W(ADDR_W), .DW(DW), .CNT_W(CNT_W),
            .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_BANK(T_BANK)
        ) u_ctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .go     (go[b]),
            .kind_i (op_kind),
            .addr_i (op_addr),
            .data_i (op_data),
            .rd_hit (rd_hit[b]),
            .busy_o (busy[b]),
            .done_o (done[b]),
            .kind_o (c_kind[b]),
            .addr_o (c_addr[b]),
            .data_o (c_data[b]),
            .poll_o (poll[b]),
            .tog_o  (tog[b])
        );
    end

    assign wr_sel = done[1];

    dbs_word_store #(
        .ADDR_W(ADDR_W), .DW(DW), .SECT_W(SECT_W), .BLK_W(BLK_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (|done),
        .wr_kind (c_kind[wr_sel]),
        .wr_addr (c_addr[wr_sel]),
        .wr_data (c_data[wr_sel]),
        .rd_addr (rd_addr),
        .rd_word (arr_word)
    );

    always_comb begin
        st_word    = '0;
        st_word[7] = poll[rd_bank];
        st_word[6] = ~tog[rd_bank];
        id_word    = rd_addr[0] ? (rd_bank ? ID_SMALL : ID_LARGE) : MAKER_ID;
        if (busy[rd_bank])
            rd_next = st_word;
        else if (rd_id && !any_busy)
            rd_next = id_word;
        else
            rd_next = arr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= rd_next;
        end
    end

    assign ryby_pull = any_busy;

    // R4: at most one bank runs an operation at any time
    p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));

    // R5: every strobe is answered in the following cycle
    p_rd_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R3: the ready/busy request falls only as a bank completes
    p_ryby_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ryby_pull) |-> $past(|done));

endmodule

// File: tb/dbs_responder_tb.sv
`timescale 1ns/1ps
module dbs_responder_tb;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TP = 3, TS = 5, TB = 7, TK = 9;
    localparam logic [15:0] MID = 16'h00A7, IDL = 16'h3C11, IDS = 16'h3C12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, rd_stb = 1'b0, rd_id = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic rd_valid, ryby_pull;
    logic [DW-1:0] rd_data;

    int vectors = 0;
    int miscompares = 0;
    logic [15:0] model [256];

    always #2.5 clk = ~clk;

    dbs_responder #(
        .ADDR_W(AW), .DW(DW), .SECT_W(3), .BLK_W(5),
        .T_PROG(TP), .T_SECT(TS), .T_BLK(TB), .T_BANK(TK),
        .MAKER_ID(MID), .ID_LARGE(IDL), .ID_SMALL(IDS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .rd_stb(rd_stb), .rd_id(rd_id),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .ryby_pull(ryby_pull)
    );

    function automatic logic [15:0] pat(input int a);
        logic [7:0] b = 8'(a);
        return {b, b ^ 8'hA5};
    endfunction

    function automatic logic [15:0] stw(input logic b7, input logic b6);
        return {8'h00, b7, b6, 6'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input bit id, input logic [15:0] exp,
                      input string req);
        rd_stb = 1'b1; rd_addr = a; rd_id = id;
        @(negedge clk);
        rd_stb = 1'b0; rd_id = 1'b0;
        chk(rd_valid === 1'b1, "R5 valid", 32'(rd_valid), 32'd1);
        chk(rd_data === exp, req, 32'(rd_data), 32'(exp));
    endtask

    task automatic start(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d);
        op_start = 1'b1; op_kind = k; op_addr = a; op_data = d;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic wait_idle(input int exp, input string req);
        int n = 0;
        while (ryby_pull === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, req, 32'(n), 32'(exp));
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 256; a++) rd(8'(a), 1'b0, model[a], req);
    endtask

    task automatic erase_model(input logic [1:0] k, input logic [7:0] t);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] x = 8'(a);
            bit hit = (k == 2'd1) ? (x[7:3] == t[7:3]) :
                      (k == 2'd2) ? (x[7:5] == t[7:5]) :
                                    ((&x[7:6]) == (&t[7:6]));
            if (hit) model[a] = 16'hFFFF;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) model[a] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ryby_pull === 1'b0, "R10 ryby", 32'(ryby_pull), 32'd0);
        chk(rd_valid === 1'b0, "R10 valid", 32'(rd_valid), 32'd0);
        sweep("R10 erased after reset");

        // R9 identification while idle, R1 bank decode
        rd(8'h00, 1'b1, MID, "R9 maker");
        rd(8'h01, 1'b1, IDL, "R9 large id");
        rd(8'hC1, 1'b1, IDS, "R9 small id R1");
        rd(8'h81, 1'b1, IDL, "R9 R1 top bits 10");
        rd(8'hC0, 1'b1, MID, "R9 maker small");

        // R2 R6 R8: program every word
        for (int a = 0; a < 256; a++) begin
            logic [15:0] d = pat(a);
            start(2'd0, 8'(a), d);
            if (a % 17 == 0) begin
                rd(8'(a), 1'b0, stw(~d[7], 1'b1), "R6 program polling");
                wait_idle(TP - 1, "R2 R3 program length");
            end else begin
                wait_idle(TP, "R2 R3 program length");
            end
            model[a] = d;
        end
        sweep("R8 program result");

        // R7 R1 R5 R9 R4 during block erase of small bank
        start(2'd2, 8'hE5, 16'h0000);
        rd(8'hE5, 1'b0, stw(1'b0, 1'b1), "R6 R7 first status");
        rd(8'hC0, 1'b0, stw(1'b0, 1'b0), "R7 R1 second status");
        rd(8'hBF, 1'b0, model[8'hBF], "R1 R5 other bank");
        rd(8'h40, 1'b1, model[8'h40], "R9 id blocked");
        rd(8'hFF, 1'b1, stw(1'b0, 1'b1), "R7 R9 busy bank status");
        start(2'd0, 8'h10, 16'h0000);
        wait_idle(TB - 6, "R4 R2 block length");
        @(negedge clk);
        chk(ryby_pull === 1'b0, "R4 no late start", 32'(ryby_pull), 32'd0);
        erase_model(2'd2, 8'hE5);
        sweep("R8 R4 block erase");

        // sector erase of large bank
        start(2'd1, 8'h13, 16'h0000);
        rd(8'h13, 1'b0, stw(1'b0, 1'b1), "R6 erase polling");
        wait_idle(TS - 1, "R2 sector length");
        erase_model(2'd1, 8'h13);
        sweep("R8 sector erase");

        // bank erase of large bank
        start(2'd3, 8'h22, 16'h0000);
        wait_idle(TK, "R2 R3 bank length");
        erase_model(2'd3, 8'h22);
        sweep("R8 large bank erase");

        // program with bit7 clear
        start(2'd0, 8'hC7, 16'h1234);
        rd(8'hC7, 1'b0, stw(1'b1, 1'b1), "R6 polling bit7 clear");
        rd(8'h05, 1'b0, model[8'h05], "R5 R1 other bank");
        wait_idle(TP - 2, "R2 program length");
        model[8'hC7] = 16'h1234;
        rd(8'hC7, 1'b0, 16'h1234, "R8 true data after");

        // bank erase of small bank
        start(2'd3, 8'hC0, 16'h0000);
        wait_idle(TK, "R2 small bank length");
        erase_model(2'd3, 8'hC0);
        sweep("R8 small bank erase");
        rd(8'hC1, 1'b1, IDS, "R9 id after completion");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule